// File: doc/BRIEF.md
# SMM Memory Window Lock Controller

This block holds one byte-wide control register in a host-bridge configuration space and uses it to guard a fixed 128 KiB stretch of low system memory that belongs to system-management mode. Firmware first probes the register to learn whether the guard exists. While the guard is only probed, the window stays open to every agent, so the management handler can be installed. Firmware then issues a lock command. From that point on, and until the next reset, code that runs outside management mode can neither read nor change the window.

Every memory access presents an address, a write flag and a management-mode flag. The block answers in the same cycle with a pass enable. When a read is refused, it also gives a byte of all ones to return in place of the memory data. The RAM, the other configuration registers and the bus protocol are outside the block.

Top module: `smm_window_guard`

## Requirements
- R1: After reset the control register (configuration offset 0x9c) reads 0x00 and the window is open: a non-management access anywhere passes.
- R2: A write of 0xff to offset 0x9c from the reset state moves the block to the probed state, and the register then reads 0x01. A further 0xff write while probed keeps it probed.
- R3: In the probed state, non-management reads and writes inside the window pass, and the fill byte is 0x00.
- R4: A write of 0x02 to offset 0x9c while probed locks the window, and the register then reads 0x02.
- R5: While locked, a non-management read at an address from 0x30000 to 0x4ffff inclusive is refused (pass low) and the fill byte is 0xff.
- R6: While locked, a non-management write inside the window is refused (pass low) and the fill byte stays 0x00.
- R7: Once locked, every register write (any value) is ignored until reset, and the register keeps reading 0x02.
- R8: Any access with the management flag high passes, locked or not.
- R9: Accesses outside the window (below 0x30000 or above 0x4ffff) pass in every state.
- R10: A write of 0x02 in the reset state, or of any value other than 0xff and 0x02 in any state, leaves the state unchanged.
- R11: Writes to configuration offsets other than 0x9c have no effect. Reads of other offsets, and cycles without a read strobe, return 0x00.
- R12: The pass enable and the fill byte depend only on the current cycle's access inputs and the current state. Pass is low whenever no access is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | Memory access is a write |
| mem_addr | input | ADDR_W | Memory byte address |
| mem_smm | input | 1 | Access originates in management mode |
| mem_pass | output | 1 | Forward the access to memory |
| mem_fill | output | 8 | Byte to return in place of a refused read |

## Verification
The assertions assume that reset is applied before any configuration write, and that the memory inputs are steady by the sampling edge, since the gating is purely combinational. The stimulus changes inputs only just after the falling edge and compares outputs a moment later. Random traffic is aimed at addresses that straddle both window edges, and the register commands are biased toward 0xff and 0x02. This reaches the probe, lock and ignored-write paths several times, in legal and illegal orders.

// File: rtl/smm_guard_pkg.sv
package smm_guard_pkg;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_PROBED = 2'd1,
        ST_LOCKED = 2'd2
    } guard_state_e;

    typedef struct packed {
        guard_state_e state;
    } guard_regs_t;

    localparam logic [7:0] CMD_PROBE  = 8'hFF;
    localparam logic [7:0] CMD_LOCK   = 8'h02;
    localparam logic [7:0] BLOCK_FILL = 8'hFF;

    function automatic logic [7:0] state_code(input guard_state_e s);
        case (s)
            ST_PROBED: return 8'h01;
            ST_LOCKED: return 8'h02;
            default:   return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smm_cfg_reg.sv
module smm_cfg_reg
    import smm_guard_pkg::*;
#(
    parameter logic [7:0] CFG_OFFSET = 8'h9C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [7:0]   addr,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output guard_state_e state
);
    guard_regs_t regs_d, regs_q;
    logic        hit;

    assign hit = (addr == CFG_OFFSET);

    always_comb begin
        regs_d = regs_q;
        if (wr_en && hit) begin
            unique case (regs_q.state)
                ST_OPEN:   if (wdata == CMD_PROBE) regs_d.state = ST_PROBED;
                ST_PROBED: if (wdata == CMD_LOCK)  regs_d.state = ST_LOCKED;
                default:   regs_d.state = regs_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: ST_OPEN};
        else        regs_q <= regs_d;
    end

    assign state = regs_q.state;
    assign rdata = (rd_en && hit) ? state_code(regs_q.state) : 8'h00;

endmodule

// File: rtl/smm_window_decode.sv
module smm_window_decode #(
    parameter int unsigned          ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]    WIN_BASE  = 32'h0003_0000,
    parameter logic [ADDR_W-1:0]    WIN_BYTES = 32'h0002_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win
);
    localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_BYTES - 1'b1;

    assign in_win = (addr >= WIN_BASE) && (addr <= WIN_LAST);

endmodule

// File: rtl/smm_access_gate.sv
module smm_access_gate
    import smm_guard_pkg::*;
(
    input  logic       req,
    input  logic       we,
    input  logic       smm,
    input  logic       in_win,
    input  logic       locked,
    output logic       pass,
    output logic [7:0] fill
);
    logic hidden;

    always_comb begin
        hidden = locked && in_win && !smm;
        pass   = req && !hidden;
        fill   = (req && hidden && !we) ? BLOCK_FILL : 8'h00;
    end

endmodule

// File: rtl/smm_window_guard.sv
module smm_window_guard
    import smm_guard_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [7:0]        CFG_OFFSET = 8'h9C,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h0003_0000,
    parameter logic [ADDR_W-1:0] WIN_BYTES  = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_smm,
    output logic              mem_pass,
    output logic [7:0]        mem_fill
);
    guard_state_e state_q;
    logic         in_win;

    smm_cfg_reg #(.CFG_OFFSET(CFG_OFFSET)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .rd_en (cfg_rd_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .state (state_q)
    );

    smm_window_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .WIN_BYTES (WIN_BYTES)
    ) u_dec (
        .addr   (mem_addr),
        .in_win (in_win)
    );

    smm_access_gate u_gate (
        .req    (mem_req),
        .we     (mem_we),
        .smm    (mem_smm),
        .in_win (in_win),
        .locked (state_q == ST_LOCKED),
        .pass   (mem_pass),
        .fill   (mem_fill)
    );

endmodule

// File: rtl/smm_window_guard_sva.sv
module smm_window_guard_sva
    import smm_guard_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [7:0]        CFG_OFFSET = 8'h9C,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h0003_0000,
    parameter logic [ADDR_W-1:0] WIN_BYTES  = 32'h0002_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_smm,
    input logic              mem_pass,
    input logic [7:0]        mem_fill,
    input guard_state_e      state_q
);
    localparam logic [ADDR_W-1:0] LAST = WIN_BASE + WIN_BYTES - 1'b1;

    logic outside;
    assign outside = (mem_addr < WIN_BASE) || (mem_addr > LAST);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOCKED |=> state_q == ST_LOCKED); // R7
    AST_NO_LOCK_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_OPEN |=> state_q != ST_LOCKED); // R10
    AST_FOREIGN_OFFSET_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && cfg_addr == CFG_OFFSET) |=> $stable(state_q)); // R11
    AST_SMM_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_smm |-> mem_pass); // R8
    AST_OUTSIDE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && outside |-> mem_pass); // R9
    AST_HIDDEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOCKED && mem_req && !mem_we && !mem_smm && !outside
        |-> !mem_pass && mem_fill == 8'hFF); // R5
    AST_HIDDEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOCKED && mem_req && mem_we && !mem_smm && !outside
        |-> !mem_pass); // R6
    AST_IDLE_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> !mem_pass && mem_fill == 8'h00); // R12
    AST_PROBED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PROBED && mem_req |-> mem_pass); // R3

endmodule

bind smm_window_guard smm_window_guard_sva #(
    .ADDR_W     (ADDR_W),
    .CFG_OFFSET (CFG_OFFSET),
    .WIN_BASE   (WIN_BASE),
    .WIN_BYTES  (WIN_BYTES)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_smm   (mem_smm),
    .mem_pass  (mem_pass),
    .mem_fill  (mem_fill),
    .state_q   (state_q)
);

// File: tb/test_smm_window_guard.sv
module test_smm_window_guard;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OFF = 8'h9C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00, cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        mem_req = 1'b0, mem_we = 1'b0, mem_smm = 1'b0;
    logic [31:0] mem_addr = 32'h0;
    logic        mem_pass;
    logic [7:0]  mem_fill;

    int checks = 0;
    int errors = 0;
    int ref_state = 0;  // 0 open, 1 probed, 2 locked

    always #(CLK_PERIOD/2) clk = ~clk;

    smm_window_guard i_smm_window_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_smm(mem_smm), .mem_pass(mem_pass), .mem_fill(mem_fill)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    // One cycle: drive after the falling edge, compare, then let the model step at the rising edge.
    task automatic cyc(input string tag, input logic cw, input logic cr,
                       input logic [7:0] ca, input logic [7:0] cd,
                       input logic mr, input logic mw, input logic [31:0] ma,
                       input logic ms);
        logic       inwin;
        logic [7:0] exp_rd;
        logic       exp_pass;
        logic [7:0] exp_fill;
        cfg_wr_en = cw; cfg_rd_en = cr; cfg_addr = ca; cfg_wdata = cd;
        mem_req = mr; mem_we = mw; mem_addr = ma; mem_smm = ms;
        #1;
        inwin    = (ma >= 32'h30000) && (ma <= 32'h4FFFF);
        exp_rd   = (cr && ca == OFF) ? 8'(ref_state) : 8'h00;
        exp_pass = mr && (ms || !inwin || ref_state != 2);
        exp_fill = (mr && !mw && !ms && inwin && ref_state == 2) ? 8'hFF : 8'h00;
        checks++;
        if (cfg_rdata !== exp_rd || mem_pass !== exp_pass || mem_fill !== exp_fill) begin
            errors++;
            $display("FAIL %s: actual rd=%h pass=%b fill=%h expected rd=%h pass=%b fill=%h",
                     tag, cfg_rdata, mem_pass, mem_fill, exp_rd, exp_pass, exp_fill);
        end
        @(posedge clk);
        if (cw && ca == OFF) begin
            if (ref_state == 0 && cd == 8'hFF) ref_state = 1;
            else if (ref_state == 1 && cd == 8'h02) ref_state = 2;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_wr_en = 1'b0; mem_req = 1'b0;
        repeat (2) @(negedge clk);
        ref_state = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        cyc("R1", 0, 1, OFF, 8'h00, 1, 0, 32'h30000, 0);
        cyc("R1", 0, 0, OFF, 8'h00, 1, 1, 32'h4FFFF, 0);
        // R10 lock before probe, stray values
        cyc("R10", 1, 0, OFF, 8'h02, 0, 0, 32'h0, 0);
        cyc("R10", 1, 1, OFF, 8'h55, 0, 0, 32'h0, 0);
        cyc("R10", 0, 1, OFF, 8'h00, 1, 0, 32'h38000, 0);
        // R11 other offset
        cyc("R11", 1, 1, 8'h9D, 8'hFF, 0, 0, 32'h0, 0);
        cyc("R11", 0, 1, OFF, 8'h00, 0, 0, 32'h0, 0);
        cyc("R11", 0, 0, OFF, 8'h00, 0, 0, 32'h0, 0);
        // R2 probe
        cyc("R2", 1, 0, OFF, 8'hFF, 0, 0, 32'h0, 0);
        cyc("R2", 0, 1, OFF, 8'h00, 0, 0, 32'h0, 0);
        cyc("R2", 1, 1, OFF, 8'hFF, 0, 0, 32'h0, 0);
        // R3 window open while probed
        cyc("R3", 0, 0, OFF, 8'h00, 1, 0, 32'h30000, 0);
        cyc("R3", 0, 0, OFF, 8'h00, 1, 1, 32'h4FFFF, 0);
        cyc("R10", 1, 1, OFF, 8'h07, 1, 0, 32'h40000, 0);
        // R4 lock
        cyc("R4", 1, 0, OFF, 8'h02, 0, 0, 32'h0, 0);
        cyc("R4", 0, 1, OFF, 8'h00, 0, 0, 32'h0, 0);
        // R5 / R6 hidden accesses, edges
        cyc("R5", 0, 0, OFF, 8'h00, 1, 0, 32'h30000, 0);
        cyc("R5", 0, 0, OFF, 8'h00, 1, 0, 32'h4FFFF, 0);
        cyc("R6", 0, 0, OFF, 8'h00, 1, 1, 32'h3ABCD, 0);
        // R9 outside edges
        cyc("R9", 0, 0, OFF, 8'h00, 1, 0, 32'h2FFFF, 0);
        cyc("R9", 0, 0, OFF, 8'h00, 1, 1, 32'h50000, 0);
        // R8 management mode
        cyc("R8", 0, 0, OFF, 8'h00, 1, 0, 32'h30000, 1);
        cyc("R8", 0, 0, OFF, 8'h00, 1, 1, 32'h4FFFF, 1);
        // R7 sticky lock
        cyc("R7", 1, 1, OFF, 8'hFF, 0, 0, 32'h0, 0);
        cyc("R7", 1, 1, OFF, 8'h00, 0, 0, 32'h0, 0);
        cyc("R7", 0, 1, OFF, 8'h00, 1, 0, 32'h31000, 0);
        // R12 idle
        cyc("R12", 0, 0, OFF, 8'h00, 0, 0, 32'h30000, 0);
        // reset clears the lock
        do_reset();
        cyc("R1", 0, 1, OFF, 8'h00, 1, 0, 32'h30000, 0);
        // random mix around the window edges
        for (int i = 0; i < 600; i++) begin
            logic [7:0] d;
            int sel = $urandom_range(0, 9);
            d = (sel < 4) ? 8'hFF : (sel < 8) ? 8'h02 : 8'($urandom);
            cyc("R12", ($urandom_range(0, 5) == 0), 1'($urandom),
                ($urandom_range(0, 7) == 0) ? 8'h9D : OFF, d,
                1'($urandom), 1'($urandom),
                $urandom_range(32'h2FFF0, 32'h50010), ($urandom_range(0, 3) == 0));
            if (i == 300) do_reset();
        end
        finish_run();
    end
endmodule